// File: doc/BRIEF.md
# Sector Erase Batching Window Controller

This block sits in front of a flash-style erase engine and gathers sector erase requests into one batch. The first sector erase request opens an acceptance window. Every further sector erase request that arrives while the window is open marks its sector in a pending bitmap and restarts the full window timeout. When the window runs out without a new request, the bitmap is frozen and handed to the erase engine together with a one-cycle start pulse.

A status bit tells software whether sectors can still be added: it is 0 while the window is open and 1 once the erase has started. While the erase runs, every command is ignored except suspend, which is forwarded to the engine as a one-cycle request. A suspend that arrives while the window is still open closes the window early, starts the erase on the sectors already queued, and forwards the suspend one cycle later. A chip erase from idle skips the window and starts at once on every sector. An erase-done input returns the block to idle.

The window length is a parameter given in microseconds and converted to clock cycles from the clock frequency parameter. The default is 50 µs at 100 MHz, which is 5000 cycles.

Top module: `erase_batch_ctrl`

## Requirements
- R1: After reset, `erase_map` is all zero and `erase_start`, `erase_locked`, `busy` and `suspend_req` are all 0.
- R2: A sector erase command (op 2'b01) taken in idle sets `busy` to 1, leaves `erase_locked` at 0, and sets bit `cmd_sector` of `erase_map`. All of these are visible after the capturing clock edge.
- R3: Every sector erase command taken while the window is open sets its own bit in `erase_map`. Bits accumulate, and repeating a sector has no further effect.
- R4: Each accepted sector erase command reloads the timeout. The erase starts exactly `TIMEOUT_CYC` cycles after the edge that captured the last accepted sector command, and not earlier.
- R5: When the window expires, `erase_start` is high for exactly one cycle. In that same cycle `erase_locked` rises from 0 to 1, and `erase_map` carries the queued sectors.
- R6: While `erase_locked` is 1, sector erase (2'b01) and chip erase (2'b10) commands change nothing: `erase_map` and `erase_locked` keep their values, and no start pulse is produced.
- R7: A suspend command (op 2'b11) taken while `erase_locked` is 1 produces a one-cycle `suspend_req`, visible after the capturing edge. The erase stays locked.
- R8: A suspend command taken while the window is open starts the erase at the capturing edge with the sectors queued so far. `suspend_req` follows one cycle after the start pulse.
- R9: A chip erase command (op 2'b10) taken in idle raises `erase_start` and `erase_locked` at the capturing edge, with `erase_map` all ones. A chip erase taken while the window is open is ignored.
- R10: `erase_done` taken while `erase_locked` is 1 returns the block to idle. After that edge, `busy` is 0, `erase_locked` is 0 and `erase_map` is all zero.
- R11: In idle, a suspend command and `erase_done` are ignored: no output changes and no pulse is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command strobe, sampled on each rising edge |
| cmd_op | input | 2 | Opcode: 00 none, 01 sector erase, 10 chip erase, 11 suspend |
| cmd_sector | input | SEC_W (4) | Sector index used by a sector erase |
| erase_done | input | 1 | Erase engine reports that the erase has finished |
| erase_map | output | 2**SEC_W (16) | Pending / frozen sector bitmap |
| erase_start | output | 1 | One-cycle pulse that starts the erase engine |
| erase_locked | output | 1 | Window status: 0 while sectors can be added, 1 once the erase has started |
| busy | output | 1 | High from the first accepted erase command until erase done |
| suspend_req | output | 1 | One-cycle suspend request forwarded to the erase engine |

## Verification
Every result comes from a register, so all results appear after the edge that captures the command, with these exceptions. A start caused by the window appears `TIMEOUT_CYC` edges after the last accepted sector command. The suspend request that follows a window-closing suspend appears one edge later than its start pulse. The bench counts rising edges, drives and samples on falling edges, and pushes the edge number and bitmap of each expected pulse into a queue before the command is issued. A monitor pops the queue whenever a pulse appears and compares both values, so a pulse that comes early, comes late or was never expected is reported. Direct checks read the window status one cycle before and at the predicted expiry, to pin the restart of the timeout.

// File: rtl/ebw_pkg.sv
// Shared types for the sector erase batching window controller.
// Assumes the opcode encoding listed in the brief.
package ebw_pkg;

    typedef enum logic [1:0] {
        OP_NONE    = 2'b00,
        OP_SECTOR  = 2'b01,
        OP_CHIP    = 2'b10,
        OP_SUSPEND = 2'b11
    } ebw_op_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'b00,
        ST_WINDOW = 2'b01,
        ST_ERASE  = 2'b10
    } ebw_state_e;

    // Commands that survived the acceptance rules of the current state
    typedef struct packed {
        logic add_sector;
        logic chip;
        logic suspend;
        logic done;
    } ebw_evt_t;

endpackage

// File: rtl/ebw_cmd_filter.sv
// Decides which incoming command is accepted in the present state.
// Assumes: at most one opcode per cycle; erase_done only meaningful while erasing.
module ebw_cmd_filter
    import ebw_pkg::*;
(
    input  logic       cmd_valid,
    input  logic [1:0] cmd_op,
    input  logic       erase_done,
    input  ebw_state_e state,
    output ebw_evt_t   evt
);

    // Acceptance rules per state: erase phase accepts only suspend and done
    always_comb begin
        evt            = '0;
        evt.add_sector = cmd_valid && (cmd_op == OP_SECTOR)  && (state != ST_ERASE);
        evt.chip       = cmd_valid && (cmd_op == OP_CHIP)    && (state == ST_IDLE);
        evt.suspend    = cmd_valid && (cmd_op == OP_SUSPEND) && (state != ST_IDLE);
        evt.done       = erase_done && (state == ST_ERASE);
    end

endmodule

// File: rtl/ebw_window_timer.sv
// Down-counter for the acceptance window. A load restarts the full timeout;
// expire is raised in the cycle whose edge ends the window.
// Assumes TIMEOUT_CYC >= 1.
module ebw_window_timer #(
    parameter int TIMEOUT_CYC = 5000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic run,
    output logic expire
);

    localparam int CW = $clog2(TIMEOUT_CYC + 1);
    localparam logic [CW-1:0] FULL = CW'(TIMEOUT_CYC);
    localparam logic [CW-1:0] LAST = CW'(1);

    logic [CW-1:0] cnt_q;

    // Window ends when the count sits at its last value and no reload arrives
    assign expire = run && !load && (cnt_q == LAST);

    // Reload on each accepted sector command, count down while the window is open
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= FULL;
        end else if (!run) begin
            cnt_q <= '0;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - LAST;
        end
    end

    // R4
    timer_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= FULL);

    // R4
    timer_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt_q == FULL));

endmodule

// File: rtl/ebw_sector_map.sv
// Holds the pending sector bitmap: sets single bits, fills all bits, or clears.
// Assumes clear, fill and set are never needed in the same cycle (clear wins).
module ebw_sector_map #(
    parameter int SEC_W = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  set_en,
    input  logic [SEC_W-1:0]      set_idx,
    input  logic                  fill_all,
    input  logic                  clear,
    output logic [(1<<SEC_W)-1:0] map
);

    localparam int NUM_SECTORS = 1 << SEC_W;

    logic [NUM_SECTORS-1:0] hit;

    // One decoder compare per sector bit
    for (genvar i = 0; i < NUM_SECTORS; i++) begin : g_hit
        assign hit[i] = set_en && (set_idx == SEC_W'(i));
    end

    // Update bitmap: clear on done, fill on chip erase, else OR in the new sector
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            map <= '0;
        end else if (clear) begin
            map <= '0;
        end else if (fill_all) begin
            map <= '1;
        end else begin
            map <= map | hit;
        end
    end

    // R3
    map_accum_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && !fill_all) |=> ((map & $past(map)) == $past(map)));

endmodule

// File: rtl/erase_batch_ctrl.sv
// Sector erase batching window controller.
// Collects sector erase commands in a timed window, then starts the erase
// engine with a frozen bitmap. While erasing only suspend and done are honoured.
// Assumes: one command per cycle, erase engine raises erase_done once per erase.
module erase_batch_ctrl
    import ebw_pkg::*;
#(
    parameter int SEC_W     = 4,
    parameter int CLK_HZ    = 100_000_000,
    parameter int WINDOW_US = 50
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cmd_valid,
    input  logic [1:0]            cmd_op,
    input  logic [SEC_W-1:0]      cmd_sector,
    input  logic                  erase_done,
    output logic [(1<<SEC_W)-1:0] erase_map,
    output logic                  erase_start,
    output logic                  erase_locked,
    output logic                  busy,
    output logic                  suspend_req
);

    localparam int NUM_SECTORS = 1 << SEC_W;
    localparam int TIMEOUT_CYC = (CLK_HZ / 1_000_000) * WINDOW_US;

    ebw_state_e state_q, state_d;
    ebw_evt_t   evt;
    logic       expire;
    logic       start_d, start_q;
    logic       susp_pend_q;
    logic       susp_req_q;

    ebw_cmd_filter u_filter (
        .cmd_valid  (cmd_valid),
        .cmd_op     (cmd_op),
        .erase_done (erase_done),
        .state      (state_q),
        .evt        (evt)
    );

    ebw_window_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (evt.add_sector),
        .run    (state_q == ST_WINDOW),
        .expire (expire)
    );

    ebw_sector_map #(.SEC_W(SEC_W)) u_map (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_en   (evt.add_sector),
        .set_idx  (cmd_sector),
        .fill_all (evt.chip),
        .clear    (evt.done),
        .map      (erase_map)
    );

    // Next-state and start decision for idle / window / erase phases
    always_comb begin
        state_d = state_q;
        start_d = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (evt.chip) begin
                    state_d = ST_ERASE;
                    start_d = 1'b1;
                end else if (evt.add_sector) begin
                    state_d = ST_WINDOW;
                end
            end
            ST_WINDOW: begin
                if (evt.suspend || expire) begin
                    state_d = ST_ERASE;
                    start_d = 1'b1;
                end
            end
            ST_ERASE: begin
                if (evt.done) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Phase register and start pulse register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            start_q <= 1'b0;
        end else begin
            state_q <= state_d;
            start_q <= start_d;
        end
    end

    // Suspend forwarding: direct while erasing, one cycle after start if it closed the window
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            susp_pend_q <= 1'b0;
            susp_req_q  <= 1'b0;
        end else begin
            susp_pend_q <= evt.suspend && (state_q == ST_WINDOW);
            susp_req_q  <= (evt.suspend && (state_q == ST_ERASE)) || susp_pend_q;
        end
    end

    assign erase_start  = start_q;
    assign erase_locked = (state_q == ST_ERASE);
    assign busy         = (state_q != ST_IDLE);
    assign suspend_req  = susp_req_q;

    // R5
    start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        erase_start |=> !erase_start);

    // R5
    lock_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(erase_locked) |-> erase_start);

    // R6
    map_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (erase_locked && !erase_done) |=> $stable(erase_map));

    // R10
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (erase_locked && erase_done) |=> (!busy && !erase_locked && (erase_map == '0)));

    // R2
    busy_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (erase_map != '0));

    // R7
    suspend_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        suspend_req |-> $past(busy));

endmodule

// File: tb/tb_erase_batch_ctrl.sv
module tb_erase_batch_ctrl;
    import ebw_pkg::*;

    localparam int SEC_W = 4;
    localparam int NS    = 1 << SEC_W;
    localparam int T     = 5000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic [1:0]    cmd_op = 2'b00;
    logic [SEC_W-1:0] cmd_sector = '0;
    logic          erase_done = 1'b0;
    logic [NS-1:0] erase_map;
    logic          erase_start;
    logic          erase_locked;
    logic          busy;
    logic          suspend_req;

    int cyc = 0;
    int errs = 0;
    int checks = 0;
    bit finished = 0;
    int st_cyc_q[$];
    logic [NS-1:0] st_map_q[$];
    int sr_q[$];

    erase_batch_ctrl dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_sector(cmd_sector), .erase_done(erase_done), .erase_map(erase_map),
        .erase_start(erase_start), .erase_locked(erase_locked), .busy(busy),
        .suspend_req(suspend_req)
    );

    always #5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Driver: one command, returns at the falling edge after the capturing edge
    task automatic send(input logic [1:0] op, input int sec);
        cmd_valid  = 1'b1;
        cmd_op     = op;
        cmd_sector = SEC_W'(sec);
        @(posedge clk);
        @(negedge clk);
        cmd_valid  = 1'b0;
        cmd_op     = 2'b00;
    endtask

    task automatic pulse_done();
        erase_done = 1'b1;
        @(posedge clk);
        @(negedge clk);
        erase_done = 1'b0;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_start(input int at, input logic [NS-1:0] m);
        st_cyc_q.push_back(at);
        st_map_q.push_back(m);
    endtask

    // Monitor: pop expected pulses as the design produces them
    always @(negedge clk) begin
        if (rst_n) begin
            if (erase_start) begin
                if (st_cyc_q.size() == 0) begin
                    chk("R5 unexpected erase_start", 1, 0);
                end else begin
                    chk("R4/R5 start cycle", cyc, st_cyc_q.pop_front());
                    chk("R5 start map", erase_map, st_map_q.pop_front());
                    chk("R5 locked with start", erase_locked, 1);
                end
            end
            if (suspend_req) begin
                if (sr_q.size() == 0) chk("R7 unexpected suspend_req", 1, 0);
                else chk("R7/R8 suspend_req cycle", cyc, sr_q.pop_front());
            end
        end
    end

    initial begin
        #2_000_000;
        if (!finished) begin
            errs++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        int c;
        wait_cyc(3);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 map", erase_map, 0);
        chk("R1 start", erase_start, 0);
        chk("R1 locked", erase_locked, 0);
        chk("R1 busy", busy, 0);
        chk("R1 suspend_req", suspend_req, 0);

        // R2 single sector opens the window, R5 expiry
        c = cyc + 1;
        expect_start(c + T, 16'h0008);
        send(OP_SECTOR, 3);
        chk("R2 busy", busy, 1);
        chk("R2 locked", erase_locked, 0);
        chk("R2 map", erase_map, 16'h0008);
        wait_cyc(T + 1);
        chk("R5 locked after expiry", erase_locked, 1);
        chk("R5 map frozen", erase_map, 16'h0008);
        // R6 commands ignored while locked
        send(OP_SECTOR, 5);
        chk("R6 map after sector", erase_map, 16'h0008);
        send(OP_CHIP, 0);
        chk("R6 map after chip", erase_map, 16'h0008);
        chk("R6 still locked", erase_locked, 1);
        // R10 done returns to idle
        pulse_done();
        chk("R10 busy", busy, 0);
        chk("R10 locked", erase_locked, 0);
        chk("R10 map", erase_map, 0);

        // R3/R4 accumulate and restart timeout
        send(OP_SECTOR, 1);
        wait_cyc(3000);
        send(OP_SECTOR, 7);
        wait_cyc(3000);
        chk("R4 window still open", erase_locked, 0);
        c = cyc + 1;
        expect_start(c + T, 16'h0082);
        send(OP_SECTOR, 1);
        wait_cyc(T - 1);
        chk("R4 open one cycle before expiry", erase_locked, 0);
        wait_cyc(1);
        chk("R4 locked at expiry", erase_locked, 1);
        chk("R3 accumulated map", erase_map, 16'h0082);
        pulse_done();

        // R9 chip erase from idle, R7 suspend while erasing
        c = cyc + 1;
        expect_start(c, 16'hFFFF);
        send(OP_CHIP, 0);
        chk("R9 locked", erase_locked, 1);
        chk("R9 map all ones", erase_map, 16'hFFFF);
        c = cyc + 1;
        sr_q.push_back(c);
        send(OP_SUSPEND, 0);
        wait_cyc(2);
        chk("R7 still locked", erase_locked, 1);
        pulse_done();

        // R9 chip ignored in window, R8 suspend closes window
        send(OP_SECTOR, 2);
        send(OP_CHIP, 0);
        chk("R9 chip ignored in window map", erase_map, 16'h0004);
        chk("R9 chip ignored in window locked", erase_locked, 0);
        c = cyc + 1;
        expect_start(c, 16'h0004);
        sr_q.push_back(c + 1);
        send(OP_SUSPEND, 0);
        chk("R8 locked", erase_locked, 1);
        chk("R8 map", erase_map, 16'h0004);
        wait_cyc(3);
        pulse_done();

        // R11 suspend and done in idle are ignored
        send(OP_SUSPEND, 0);
        pulse_done();
        wait_cyc(3);
        chk("R11 busy", busy, 0);
        chk("R11 locked", erase_locked, 0);
        chk("R11 map", erase_map, 0);
        chk("R11 suspend_req", suspend_req, 0);

        wait_cyc(5);
        chk("R5 all starts seen", st_cyc_q.size(), 0);
        chk("R7 all suspends seen", sr_q.size(), 0);
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule